// File: doc/BRIEF.md
# Dot-Wire Drive-Time Corrector

This block sets the energising time of each of the 18 wires of an impact dot-matrix print head, one column at a time. The wires sit in two rows of nine. A column enters as an 18-bit dot pattern with a 3-bit head-gap code on a valid/ready stream. Every wire whose dot bit is set then gets two drive enables. The phase-2 enable lasts a fixed basic time. The phase-1 enable lasts the basic time plus three corrections: a per-count addend from a programmable table indexed by the number of dots in the column, an extra amount when a row neighbour fired in the previous column, and a step that grows with the head gap.

The block also watches print duty across each line and raises a two-pass request. It does this when the seven lines just closed were all heavy, meaning more than 60 % of the possible dots were set. It also does this when the current line contains a column with 12 or more dots. A `line_end` pulse closes a line. A column accepted in the same cycle as `line_end` belongs to the line being closed.

Back-pressure works as follows. `col_ready` is low while any phase-1 enable is high. A column is taken on a cycle with `col_valid` and `col_ready` both high. A source may keep `col_valid` asserted against a low `col_ready`, and the column is then taken once ready returns. Each such cycle is also reported on `overrun` and leaves the pulses in flight untouched.

Top module: `headdrive_corrector`

## Requirements
- R1: After reset `col_ready` is 1 and `drv_ph1`, `drv_ph2`, `overrun` and `twopass_req` are all 0. `col_ready` is 0 in every cycle in which any `drv_ph1` bit is 1. No phase-1 bit rises except in the cycle after an acceptance.
- R2: For every set bit of an accepted column, the matching `drv_ph2` bit is 1 for exactly 20 cycles, starting the cycle after acceptance. Wires whose dot bit is 0 drive neither output.
- R3: For a set dot bit, `drv_ph1` starts in the same cycle as `drv_ph2` and lasts 20 + T[n] + A + G cycles. T[n] is the table entry for the column's dot count n. A is the adjacency term (R5). G is the gap term (R6).
- R4: The table has 19 six-bit entries at addresses 0 to 18, where the address is the dot count. An entry is written with `tbl_we` high, `tbl_addr` and `tbl_data`. All entries are 0 after reset. Writes to addresses 19 to 31 change nothing.
- R5: A is 2 when a row neighbour of the wire fired in the previously accepted column of the same line, and 0 otherwise. Row neighbours are the wires one position to either side in the same row. Wires 0–8 form one row and wires 9–17 the other, so wires 8 and 9 are not neighbours. `line_end` clears this history.
- R6: For gap codes 1 to 5, G = (code − 1) × 3. Code 0 counts as 1, and codes 6 and 7 count as 5.
- R7: A cycle with `col_valid` high and `col_ready` low sets `overrun` high in the next cycle and alters no pulse in flight.
- R8: A closed line is heavy when 100 × dots > 1080 × columns. From the cycle after a `line_end`, `twopass_req` is high if the last seven closed lines were all heavy. It stays high while heavy lines continue and drops after a line that is not heavy closes.
- R9: Accepting a column with 12 or more dots raises `twopass_req` from the next cycle until `line_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| col_valid | input | 1 | column offered |
| col_ready | output | 1 | column can be taken |
| col_dots | input | 18 | dot pattern, bit i = wire i |
| col_gap | input | 3 | head-gap code |
| line_end | input | 1 | closes the current line |
| tbl_we | input | 1 | table write enable |
| tbl_addr | input | 5 | table entry address |
| tbl_data | input | 6 | table entry value |
| drv_ph1 | output | 18 | phase-1 drive enables |
| drv_ph2 | output | 18 | phase-2 drive enables |
| overrun | output | 1 | column offered while busy |
| twopass_req | output | 1 | two-pass printing request |

## Verification
The embedded properties assume that the basic time is at least one cycle, so that phase 2 is visible in the cycle after acceptance. They also assume that the basic time plus the largest corrections fits the pulse counter without reaching its saturation value. The table and gap defaults keep the longest pulse near 100 cycles, well under that limit. The stimulus never raises `line_end` in the same cycle as an acceptance. It holds `col_valid` against a low `col_ready` for only one cycle, and only while a pulse has many cycles left, so an overrun never turns into a late acceptance.

// File: rtl/hdc_pkg.sv
`timescale 1ns/1ps
package hdc_pkg;
  // head-gap code to step index 0..4, out-of-range codes clamped
  function automatic logic [2:0] gap_rank(input logic [2:0] code);
    if (code <= 3'd1) return 3'd0;
    else if (code >= 3'd5) return 3'd4;
    else return code - 3'd1;
  endfunction
endpackage

// File: rtl/hdc_comp_table.sv
`timescale 1ns/1ps
module hdc_comp_table #(
  parameter int NENT = 19,
  parameter int TW   = 6,
  parameter int AW   = 5
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [TW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [TW-1:0] rdata
);
  logic [NENT-1:0][TW-1:0] mem;

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[e] <= '0;
      else if (we && waddr == AW'(e)) mem[e] <= wdata;
    end
  end

  assign rdata = (raddr < AW'(NENT)) ? mem[raddr] : '0;

  // R4: an in-range write lands in the addressed entry
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr < AW'(NENT)) |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/hdc_pin_lengths.sv
`timescale 1ns/1ps
module hdc_pin_lengths #(
  parameter int NPIN   = 18,
  parameter int ROW    = 9,
  parameter int TW     = 6,
  parameter int LENW   = 8,
  parameter int BASE_T = 20,
  parameter int ADJ_T  = 2,
  parameter int GAP_T  = 3
)(
  input  logic [NPIN-1:0]           hist,
  input  logic [TW-1:0]             addend,
  input  logic [2:0]                rank,
  output logic [NPIN-1:0][LENW-1:0] len
);
  localparam logic [LENW-1:0] COMMON_BASE = LENW'(BASE_T);

  logic [LENW-1:0] common;
  assign common = COMMON_BASE + LENW'(addend) + LENW'(32'(rank) * GAP_T);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    localparam int POS = i % ROW;
    logic nb;
    if (POS == 0) begin : g_first
      assign nb = hist[i+1];
    end else if (POS == ROW-1) begin : g_last
      assign nb = hist[i-1];
    end else begin : g_mid
      assign nb = hist[i-1] | hist[i+1];
    end
    assign len[i] = common + (nb ? LENW'(ADJ_T) : '0);
  end
endmodule

// File: rtl/hdc_duty_mon.sv
`timescale 1ns/1ps
module hdc_duty_mon #(
  parameter int NPIN      = 18,
  parameter int COLW      = 12,
  parameter int HEAVY_RUN = 8,
  parameter int HEAVY_PCT = 60,
  parameter int DENSE     = 12,
  parameter int CW        = 5
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [CW-1:0] cnt,
  input  logic          line_end,
  output logic          twopass_req
);
  localparam int DW = COLW + CW;
  localparam int MW = DW + 7;
  localparam int SW = $clog2(HEAVY_RUN);
  localparam logic [SW-1:0] SMAX = SW'(HEAVY_RUN - 1);

  logic [COLW-1:0] cols_q, cols_n;
  logic [DW-1:0]   dots_q, dots_n;
  logic [SW-1:0]   streak_q;
  logic            dense_q, heavy;

  always_comb begin
    cols_n = cols_q;
    dots_n = dots_q;
    if (accept && cols_q != '1) begin
      cols_n = cols_q + 1'b1;
      dots_n = dots_q + DW'(cnt);
    end
  end

  assign heavy = (MW'(dots_n) * MW'(100)) > (MW'(cols_n) * MW'(NPIN * HEAVY_PCT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cols_q   <= '0;
      dots_q   <= '0;
      streak_q <= '0;
      dense_q  <= 1'b0;
    end else if (line_end) begin
      cols_q   <= '0;
      dots_q   <= '0;
      dense_q  <= 1'b0;
      streak_q <= !heavy ? '0 : (streak_q == SMAX ? SMAX : streak_q + 1'b1);
    end else begin
      cols_q <= cols_n;
      dots_q <= dots_n;
      if (accept && cnt >= CW'(DENSE)) dense_q <= 1'b1;
    end
  end

  assign twopass_req = dense_q | (streak_q == SMAX);

  // R8: a light line breaks the heavy run
  a_r8_light_line_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !heavy) |=> streak_q == '0);
  // R9: dense flag lives only until the line closes
  a_r9_dense_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> !dense_q);
endmodule

// File: rtl/headdrive_corrector.sv
`timescale 1ns/1ps
module headdrive_corrector import hdc_pkg::*; #(
  parameter int NPIN       = 18,
  parameter int ROW        = 9,
  parameter int TW         = 6,
  parameter int LENW       = 8,
  parameter int BASE_T     = 20,
  parameter int ADJ_T      = 2,
  parameter int GAP_T      = 3,
  parameter int COLW       = 12,
  parameter int HEAVY_RUN  = 8,
  parameter int HEAVY_PCT  = 60,
  parameter int DENSE_PINS = 12
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      col_valid,
  output logic                      col_ready,
  input  logic [NPIN-1:0]           col_dots,
  input  logic [2:0]                col_gap,
  input  logic                      line_end,
  input  logic                      tbl_we,
  input  logic [$clog2(NPIN+1)-1:0] tbl_addr,
  input  logic [TW-1:0]             tbl_data,
  output logic [NPIN-1:0]           drv_ph1,
  output logic [NPIN-1:0]           drv_ph2,
  output logic                      overrun,
  output logic                      twopass_req
);
  localparam int CW = $clog2(NPIN+1);

  logic                      accept;
  logic [CW-1:0]             cnt;
  logic [TW-1:0]             addend;
  logic [NPIN-1:0][LENW-1:0] len_w, len_q;
  logic [NPIN-1:0]           dots_q, hist_q;
  logic [LENW-1:0]           elapsed_q;

  assign accept = col_valid & col_ready;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NPIN; i++) cnt = cnt + CW'(col_dots[i]);
  end

  hdc_comp_table #(.NENT(NPIN+1), .TW(TW), .AW(CW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_data),
    .raddr(cnt), .rdata(addend));

  hdc_pin_lengths #(.NPIN(NPIN), .ROW(ROW), .TW(TW), .LENW(LENW),
    .BASE_T(BASE_T), .ADJ_T(ADJ_T), .GAP_T(GAP_T)) u_len (
    .hist(hist_q), .addend(addend), .rank(gap_rank(col_gap)), .len(len_w));

  hdc_duty_mon #(.NPIN(NPIN), .COLW(COLW), .HEAVY_RUN(HEAVY_RUN),
    .HEAVY_PCT(HEAVY_PCT), .DENSE(DENSE_PINS), .CW(CW)) u_duty (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cnt(cnt),
    .line_end(line_end), .twopass_req(twopass_req));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dots_q    <= '0;
      len_q     <= '0;
      elapsed_q <= '0;
      hist_q    <= '0;
      overrun   <= 1'b0;
    end else begin
      overrun <= col_valid & ~col_ready;
      if (accept) begin
        dots_q    <= col_dots;
        len_q     <= len_w;
        elapsed_q <= '0;
      end else if (elapsed_q != '1) begin
        elapsed_q <= elapsed_q + 1'b1;
      end
      if (line_end) hist_q <= '0;
      else if (accept) hist_q <= col_dots;
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_drv
    assign drv_ph1[i] = dots_q[i] & (elapsed_q < len_q[i]);
    assign drv_ph2[i] = dots_q[i] & (elapsed_q < LENW'(BASE_T));
  end

  assign col_ready = ~|drv_ph1;

  // R1: enables only rise right after an acceptance
  a_r1_no_rise_midpulse: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ((drv_ph1 & ~$past(drv_ph1)) == '0));
  // R2: phase 2 opens on exactly the accepted dots
  a_r2_ph2_follows_dots: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> drv_ph2 == $past(col_dots));
  // R3: phase 2 never outlasts phase 1
  a_r3_ph2_within_ph1: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_ph2 & ~drv_ph1) == '0);
  // R7: offering against a busy block is flagged
  a_r7_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready) |=> overrun);
endmodule

// File: tb/sim_headdrive_corrector.sv
`timescale 1ns/1ps
module sim_headdrive_corrector;
  logic clk = 0, rst_n = 0;
  logic col_valid = 0, line_end = 0, tbl_we = 0;
  logic [17:0] col_dots = '0;
  logic [2:0]  col_gap = '0;
  logic [4:0]  tbl_addr = '0;
  logic [5:0]  tbl_data = '0;
  logic        col_ready, overrun, twopass_req;
  logic [17:0] drv_ph1, drv_ph2;

  headdrive_corrector u0 (.*);

  always #10 clk = ~clk;

  int vectors = 0, fails = 0;
  bit done = 0;
  int tblm[19];
  logic [17:0] prev_m = '0;
  int cols_m = 0, dots_m = 0, streak_m = 0;
  bit dense_m = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ones(input logic [17:0] d);
    int n = 0;
    for (int i = 0; i < 18; i++) n += d[i];
    return n;
  endfunction

  function automatic bit nbr(input int p, input logic [17:0] h);
    int q = p % 9;
    bit a = 0;
    if (q > 0 && h[p-1]) a = 1;
    if (q < 8 && h[p+1]) a = 1;
    return a;
  endfunction

  function automatic int gstep(input int g);
    int r = (g <= 1) ? 0 : (g >= 5 ? 4 : g - 1);
    return r * 3;
  endfunction

  task automatic twrite(input int a, input int d);
    tbl_we = 1; tbl_addr = 5'(a); tbl_data = 6'(d);
    @(negedge clk);
    tbl_we = 0;
    if (a < 19) tblm[a] = d;
  endtask

  task automatic fire(input logic [17:0] d, input int g, input string tag, input bit inj);
    int w1[18], w2[18], exp1[18];
    int n = ones(d);
    for (int p = 0; p < 18; p++) begin
      w1[p] = 0; w2[p] = 0;
      exp1[p] = d[p] ? 20 + tblm[n] + (nbr(p, prev_m) ? 2 : 0) + gstep(g) : 0;
    end
    for (int k = 0; k < 500 && !col_ready; k++) @(negedge clk);
    col_valid = 1; col_dots = d; col_gap = 3'(g);
    @(negedge clk);
    col_valid = 0;
    prev_m = d; cols_m++; dots_m += n;
    if (n >= 12) dense_m = 1;
    for (int it = 0; it < 400; it++) begin
      if (it == 0) begin
        chk(overrun == 0, "R7", overrun, 0);
        chk(twopass_req == (dense_m || streak_m == 7), "R9", twopass_req, dense_m || streak_m == 7);
      end
      if (it == 1 && inj) begin col_valid = 1; col_dots = ~d; end
      if (it == 2 && inj) begin
        chk(overrun == 1, "R7", overrun, 1);
        col_valid = 0;
      end
      if (drv_ph1 != '0) chk(col_ready == 0, "R1", col_ready, 0);
      if (col_ready) break;
      for (int p = 0; p < 18; p++) begin
        w1[p] += drv_ph1[p];
        w2[p] += drv_ph2[p];
      end
      @(negedge clk);
    end
    for (int p = 0; p < 18; p++) begin
      chk(w2[p] == (d[p] ? 20 : 0), "R2", w2[p], d[p] ? 20 : 0);
      chk(w1[p] == exp1[p], tag, w1[p], exp1[p]);
    end
  endtask

  task automatic end_line();
    bit heavy = (dots_m * 100) > (cols_m * 1080);
    line_end = 1;
    @(negedge clk);
    line_end = 0;
    streak_m = heavy ? (streak_m < 7 ? streak_m + 1 : 7) : 0;
    dense_m = 0; cols_m = 0; dots_m = 0; prev_m = '0;
    chk(twopass_req == (streak_m == 7), "R8", twopass_req, streak_m == 7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 19; e++) tblm[e] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(col_ready == 1, "R1", col_ready, 1);
    chk(drv_ph1 == '0, "R1", drv_ph1, 0);
    chk(drv_ph2 == '0, "R1", drv_ph2, 0);
    chk(overrun == 0, "R1", overrun, 0);
    chk(twopass_req == 0, "R1", twopass_req, 0);
    rst_n = 1;
    @(negedge clk);
    // R4: zeroed table after reset
    fire(18'h00001, 1, "R4", 0);
    end_line();
    for (int e = 0; e < 19; e++) twrite(e, (e * 13 + 5) % 64);
    // R3 / R6: sweep every gap code over every dot count
    for (int g = 0; g < 8; g++) begin
      for (int k = 0; k <= 18; k++) begin
        logic [17:0] d = 18'((((1 << k) - 1) << (g % 4)));
        fire(d, g, (g == 0 || g > 5) ? "R6" : "R3", 0);
      end
      end_line();
    end
    // R5: row neighbours and history clear
    fire(18'h00010, 2, "R5", 0);
    fire(18'h0232C, 2, "R5", 0);
    fire(18'h00100, 2, "R5", 0);
    fire(18'h00200, 2, "R5", 0);
    fire(18'h00500, 3, "R5", 0);
    end_line();
    fire(18'h00008, 3, "R5", 0);
    end_line();
    // R4: out-of-range writes ignored, in-range rewrite takes effect
    for (int a = 19; a < 32; a++) twrite(a, 63);
    twrite(5, 40);
    fire(18'h0001F, 4, "R4", 0);
    fire(18'h3FFFF, 4, "R4", 0);
    end_line();
    // R7: offer while busy
    fire(18'h0F0F0, 1, "R7", 1);
    end_line();
    // R8: heavy run, exact-60 % boundary, 55-dot run
    for (int l = 0; l < 8; l++) begin
      for (int c = 0; c < 5; c++) fire(18'h007FF, 1, "R3", 0);
      end_line();
    end
    for (int c = 0; c < 4; c++) fire(18'h007FF, 1, "R3", 0);
    fire(18'h003FF, 1, "R3", 0);
    end_line();
    for (int l = 0; l < 7; l++) begin
      for (int c = 0; c < 4; c++) fire(18'h007FF, 1, "R3", 0);
      fire(18'h007FF, 1, "R3", 0);
      end_line();
    end
    fire(18'h00000, 1, "R3", 0);
    end_line();
    // R9: a single dense column in a light line
    fire(18'h00000, 1, "R3", 0);
    fire(18'h00FFF, 1, "R9", 0);
    fire(18'h00000, 1, "R3", 0);
    end_line();
    fire(18'h007FF, 1, "R9", 0);
    end_line();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule